// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Flags

This block is the arithmetic unit of the execute stage in a simple 64-bit in-order processor. It takes two operands and a function selector and produces a result word. It performs addition, subtraction, bitwise AND and bitwise XOR. Subtraction reuses the adder: the A operand is inverted and the carry-in is forced high, so the result is B + ~A + 1 = B − A. The same add path also forms effective addresses for memory instructions (base plus displacement). For those, the caller leaves the flag-load strobe low.

A three-bit flag register holds zero, sign and overflow. It loads from the current result only when the flag-load strobe is high, which is true only for register-register arithmetic/logic instructions. A condition evaluator reads the stored flags and a condition selector. It produces the taken/move signal that conditional jumps and conditional moves use in the execute stage. The evaluator always reads the registered flags, never the flags being computed in the same cycle.

Top module: `exec_alu`

## Requirements
- R1: With op_sel = 0 the result is opnd_b + opnd_a, modulo 2^64 (for example 5 + 7 = 12, and 0xee0 + 4 = 0xee4).
- R2: With op_sel = 1 the result is opnd_b − opnd_a, modulo 2^64.
- R3: With op_sel = 2 the result is opnd_b & opnd_a, and with op_sel = 3 it is opnd_b ^ opnd_a (for example 5 & 7 = 5).
- R4: Any op_sel from 4 to 15 gives a result of zero.
- R5: The result is combinational. It reflects the inputs in the same cycle, with no register between them.
- R6: On a rising clock edge with flag_ld = 1, the flag register loads zf = (result == 0) and sf = result bit 63. It also loads of = signed overflow of the add or subtract; of is cleared for AND, XOR and the unused codes. Flag bit order on flags_q is {zf, sf, of} = bits [2:0].
- R7: When flag_ld = 0, the flags hold their value whatever the operands and op_sel are.
- R8: A synchronous reset (rst_n low at a rising edge) sets the flags to zf=1, sf=0, of=0. Reset takes priority over flag_ld.
- R9: cond_ok is a combinational function of the stored flags and cond_sel: 0 always 1; 1 (sf^of)|zf; 2 sf^of; 3 zf; 4 !zf; 5 !(sf^of); 6 !(sf^of)&!zf; 7 to 15 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | 64 | First operand (subtrahend for subtract) |
| opnd_b | input | 64 | Second operand |
| op_sel | input | 4 | Function selector |
| flag_ld | input | 1 | Load strobe for the flag register |
| cond_sel | input | 4 | Condition selector for jumps and moves |
| result | output | 64 | Combinational result |
| flags_q | output | 3 | Stored flags {zf, sf, of} |
| cond_ok | output | 1 | Condition met by the stored flags |

## Verification
The two functions that share a cycle are flag update and condition evaluation. An instruction that loads the flags can sit in the same cycle as a jump or move that reads them. The bench provokes this by holding a condition selector while a flag-setting operation is applied with flag_ld high. It checks that cond_ok before the edge follows the old flags and that cond_ok after the edge follows the new ones. It also drives operations that would flip the flags with flag_ld low, and checks that cond_ok for every selector stays unchanged.

// File: rtl/exec_alu_pkg.sv
// Package: shared widths, function and condition codes for the execute ALU.
// Assumes a 64-bit datapath and 4-bit selectors.
package exec_alu_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned SEL_W  = 4;
    localparam int unsigned FLAG_W = 3;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        CC_ALWAYS = 4'd0,
        CC_LE     = 4'd1,
        CC_LT     = 4'd2,
        CC_EQ     = 4'd3,
        CC_NE     = 4'd4,
        CC_GE     = 4'd5,
        CC_GT     = 4'd6
    } cond_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;
endpackage

// File: rtl/exec_alu_adder.sv
// Adder shared by add and subtract. When sub_en is high, the A operand is
// inverted and the carry-in is forced to 1, giving b - a.
// Assumes two's-complement operands. The overflow output is the signed overflow of the operation actually performed.
module exec_alu_adder #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] a_eff;

    // Condition the A operand for add or subtract, then sum with carry-in.
    always_comb begin
        a_eff = sub_en ? ~a : a;
        sum   = b + a_eff + {{(W-1){1'b0}}, sub_en};
        ovf   = (a_eff[W-1] == b[W-1]) && (sum[W-1] != b[W-1]);
    end
endmodule

// File: rtl/exec_alu_cond.sv
// Condition evaluator: maps a selector and the stored flags to taken/move.
// Assumes the flags come from a register (no same-cycle bypass).
module exec_alu_cond
    import exec_alu_pkg::*;
(
    input  flags_t           flags,
    input  logic [SEL_W-1:0] sel,
    output logic             ok
);
    logic lt;

    // Decode the selected condition from the flag combinations.
    always_comb begin
        lt = flags.sf ^ flags.of;
        unique case (sel)
            CC_ALWAYS: ok = 1'b1;
            CC_LE:     ok = lt | flags.zf;
            CC_LT:     ok = lt;
            CC_EQ:     ok = flags.zf;
            CC_NE:     ok = ~flags.zf;
            CC_GE:     ok = ~lt;
            CC_GT:     ok = ~lt & ~flags.zf;
            default:   ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/exec_alu.sv
// Top of the execute ALU: function mux, flag register and condition check.
// Assumes flag_ld is high only for register-register arithmetic/logic ops.
module exec_alu
    import exec_alu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     opnd_a,
    input  logic [DATA_W-1:0]     opnd_b,
    input  logic [SEL_W-1:0]      op_sel,
    input  logic                  flag_ld,
    input  logic [SEL_W-1:0]      cond_sel,
    output logic [DATA_W-1:0]     result,
    output logic [FLAG_W-1:0]     flags_q,
    output logic                  cond_ok
);
    logic [DATA_W-1:0] sum;
    logic              add_ovf;
    logic              is_arith;
    flags_t            flags_r;
    flags_t            flags_nx;

    exec_alu_adder #(.W(DATA_W)) adder_i (
        .a      (opnd_a),
        .b      (opnd_b),
        .sub_en (op_sel == OP_SUB),
        .sum    (sum),
        .ovf    (add_ovf)
    );

    // Select the result for the requested function.
    always_comb begin
        is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);
        case (op_sel)
            OP_ADD, OP_SUB: result = sum;
            OP_AND:         result = opnd_b & opnd_a;
            OP_XOR:         result = opnd_b ^ opnd_a;
            default:        result = '0;
        endcase
        flags_nx.zf = (result == '0);
        flags_nx.sf = result[DATA_W-1];
        flags_nx.of = is_arith & add_ovf;
    end

    // Flag register: reset to zero-flag set, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       flags_r <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
        else if (flag_ld) flags_r <= flags_nx;
    end

    exec_alu_cond cond_i (
        .flags (flags_r),
        .sel   (cond_sel),
        .ok    (cond_ok)
    );

    assign flags_q = flags_r;

    // R8: reset state after a reset edge
    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 3'b100));
    // R7: flags hold without strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_ld |=> $stable(flags_q));
    // R6: logic ops never leave overflow set
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld && !is_arith) |=> !flags_q[0]);
    // R6: zero result loads zf
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld && result == '0) |=> flags_q[2]);
    // R4: unused codes give zero
    p_unused_zero_r4: assert property (@(posedge clk)
        (op_sel > 4'd3) |-> (result == '0));
    // R9: always-condition is true
    p_always_r9: assert property (@(posedge clk)
        (cond_sel == 4'd0) |-> cond_ok);
endmodule

// File: tb/exec_alu_tb_top.sv
module exec_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  op_sel = '0, cond_sel = '0;
    logic        flag_ld = 1'b0;
    logic [63:0] result;
    logic [2:0]  flags_q;
    logic        cond_ok;
    int n_chk = 0, n_bad = 0;
    logic [2:0] exp_fl;

    always #2.5 clk = ~clk;

    exec_alu dut_i (.clk, .rst_n, .opnd_a, .opnd_b, .op_sel, .flag_ld,
                    .cond_sel, .result, .flags_q, .cond_ok);

    function automatic logic [63:0] ref_res(logic [3:0] op, logic [63:0] a, logic [63:0] b);
        case (op)
            4'd0: return b + a;
            4'd1: return b - a;
            4'd2: return b & a;
            4'd3: return b ^ a;
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic ref_ovf(logic [3:0] op, logic [63:0] a, logic [63:0] b);
        logic signed [64:0] w;
        if (op == 4'd0) w = $signed({b[63], b}) + $signed({a[63], a});
        else if (op == 4'd1) w = $signed({b[63], b}) - $signed({a[63], a});
        else return 1'b0;
        return w[64] != w[63];
    endfunction

    function automatic logic ref_cond(logic [3:0] c, logic [2:0] f);
        logic z, s, o;
        {z, s, o} = f;
        case (c)
            4'd0: return 1'b1;
            4'd1: return (s ^ o) | z;
            4'd2: return s ^ o;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return !(s ^ o);
            4'd6: return !(s ^ o) && !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Sweep all condition selectors against the expected flags.
    task automatic chk_conds(string req, logic [2:0] f);
        for (int c = 0; c < 16; c++) begin
            cond_sel = c[3:0];
            #0.5;
            chk(req, {63'd0, cond_ok}, {63'd0, ref_cond(c[3:0], f)});
        end
    endtask

    // Apply one op; check result (R1-style combinational) and flags after edge.
    task automatic apply(logic [3:0] op, logic [63:0] a, logic [63:0] b, logic ld);
        logic [63:0] r;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; flag_ld = ld;
        #0.5;
        r = ref_res(op, a, b);
        if (op == 4'd0) chk("R1", result, r);
        else if (op == 4'd1) chk("R2", result, r);
        else if (op < 4'd4) chk("R3", result, r);
        else chk("R4", result, r);
        if (ld) exp_fl = {r == 64'd0, r[63], ref_ovf(op, a, b)};
        @(negedge clk);
        flag_ld = 1'b0;
        chk(ld ? "R6" : "R7", {61'd0, flags_q}, {61'd0, exp_fl});
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    localparam logic [63:0] MAXP = 64'h7fff_ffff_ffff_ffff;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

    initial begin
        logic [63:0] pat [8];
        pat = '{64'd0, 64'd1, 64'd5, 64'd7, MAXP, MINN, '1, 64'h0123_4567_89ab_cdef};
        // R8: reset state, with flag_ld high to show reset priority
        flag_ld = 1'b1; opnd_a = 64'd1; opnd_b = 64'd1; op_sel = 4'd0;
        repeat (3) @(negedge clk);
        chk("R8", {61'd0, flags_q}, 64'd4);
        exp_fl = 3'b100;
        chk_conds("R9", exp_fl);
        flag_ld = 1'b0;
        rst_n = 1'b1;
        // R1/R3 named examples, R5 same-cycle result
        @(negedge clk);
        op_sel = 4'd0; opnd_a = 64'd5; opnd_b = 64'd7; #0.5;
        chk("R1", result, 64'd12);
        opnd_a = 64'd4; opnd_b = 64'hee0; #0.5;
        chk("R5", result, 64'hee4);
        op_sel = 4'd2; opnd_a = 64'd5; opnd_b = 64'd7; #0.5;
        chk("R3", result, 64'd5);
        // Near-exhaustive sweep over ops and operand patterns
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(o[3:0], pat[i], pat[j], ((i + j + o) % 3) != 0);
        // R9 same-cycle: flag update and condition evaluation
        apply(4'd1, 64'd3, 64'd3, 1'b1);   // zero result
        for (int k = 0; k < 4; k++) begin
            logic [63:0] a, b;
            logic [2:0]  nf;
            logic [63:0] r;
            a = pat[k + 1]; b = pat[7 - k];
            @(negedge clk);
            cond_sel = 4'd3; op_sel = 4'd1; opnd_a = a; opnd_b = b; flag_ld = 1'b1;
            #0.5;
            chk("R9", {63'd0, cond_ok}, {63'd0, ref_cond(4'd3, exp_fl)});
            r = b - a;
            nf = {r == 64'd0, r[63], ref_ovf(4'd1, a, b)};
            @(negedge clk);
            flag_ld = 1'b0;
            exp_fl = nf;
            chk_conds("R9", exp_fl);
        end
        // R7: operations that would change flags, strobe low
        apply(4'd0, MAXP, 64'd1, 1'b0);
        chk_conds("R7", exp_fl);
        apply(4'd0, 64'd0, 64'd0, 1'b0);
        chk_conds("R7", exp_fl);
        // R6: overflow cases and flag encodings
        apply(4'd0, MAXP, 64'd1, 1'b1);
        chk("R6", {61'd0, flags_q}, 64'b011);
        chk_conds("R9", exp_fl);
        apply(4'd1, 64'd1, MINN, 1'b1);
        chk("R6", {61'd0, flags_q}, 64'b001);
        chk_conds("R9", exp_fl);
        apply(4'd3, '1, '1, 1'b1);
        chk("R6", {61'd0, flags_q}, 64'b100);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule